// File: doc/BRIEF.md
# VFD Grid Scan and Key Matrix Controller

This block drives a grid-type vacuum fluorescent display by time multiplexing. A frame is a sequence of 1 to `MAX_GRIDS` timing slots. In each slot exactly one grid line is driven and the 32-bit anode pattern stored for that slot is placed on the segment outputs. A dimmer value darkens the start of every slot. Every slot opens with at least one dark tick, so no anode pattern meets the wrong grid when the display moves on to the next slot.

The same scan drives a key matrix. The first 16 grid lines double as scan lines. At the last tick of each lit slot, the 8 key-return inputs are captured into the row register for that scan line. At the end of each frame a change flag reports whether any captured row differed from its stored value. A host writes the display RAM through a simple write port. The RAM is double-buffered, so host writes, the grid count and the dimmer value take effect together at the next frame boundary.

The scan is a two-state machine. `ST_BLANK` holds grid and segments dark. It moves to `ST_LIT` on the prescaler tick that ends dark tick `dim_eff-1`. `ST_LIT` drives the grid and the segments. It returns to `ST_BLANK` on the tick that ends the last tick of the slot. That same edge either advances to the next slot or, after the final slot, wraps to slot 0 and latches the new frame configuration.

Top module: `vfd_key_scanner`

## Requirements
- R1: After reset `grid_o` and `seg_o` are all zero, every key row reads 0, `key_chg_o` is 0, the display buffers hold zeros, the dimmer is 0, and the first frame scans exactly one slot (grid 0).
- R2: At most one bit of `grid_o` is high. Within a frame the slots light in the order grid 0, 1, … N-1, and then the scan wraps to grid 0.
- R3: While `grid_o` bit k is high, `seg_o` equals display row k of the current frame. While `grid_o` is zero, `seg_o` is zero.
- R4: The grid count N comes from `cfg_grids`. A value of 0 gives N = 1, and a value above `MAX_GRIDS` gives N = `MAX_GRIDS`.
- R5: One tick is `PRESC_DIV` clocks and one slot is `SLOT_TICKS` ticks. The first `dim_eff` ticks of a slot are dark, where `dim_eff` is the dimmer value clamped to the range 1..`SLOT_TICKS`-1. Each slot is therefore lit for (`SLOT_TICKS`-`dim_eff`)·`PRESC_DIV` clocks, and a grid is never followed directly by a different grid.
- R6: A write with `host_we`=1 stores `host_wdata` at row `host_addr` when the address is below `MAX_GRIDS`. A write to any higher address changes nothing. A stored row first appears on `seg_o` in the frame after the write.
- R7: `cfg_grids` and `cfg_dim` are latched only at a frame boundary. A change in the middle of a frame does not affect the rest of that frame.
- R8: At the last tick of each scanned slot k < 16, `key_ret_i` is stored as key row k. Rows of slots that are not scanned keep their values. `key_row_o` shows the row selected by `key_sel`.
- R9: At each frame end, `key_chg_o` becomes 1 if any row captured in that frame differed from its stored value, and 0 otherwise. It holds that value until the next frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Display RAM write strobe |
| host_addr | input | $clog2(MAX_GRIDS) | Display row to write |
| host_wdata | input | SEG_W | Segment pattern to write |
| cfg_grids | input | $clog2(MAX_GRIDS+1) | Requested grid count |
| cfg_dim | input | DIM_W | Dimmer value, in dark ticks per slot |
| key_ret_i | input | KEY_COLS | Key-return inputs |
| key_sel | input | $clog2(KEY_ROWS) | Key row read select |
| key_row_o | output | KEY_COLS | Selected key row |
| key_chg_o | output | 1 | Key change seen in the previous frame |
| grid_o | output | MAX_GRIDS | One-hot grid drive |
| seg_o | output | SEG_W | Anode segment drive |

## Verification
A reference model in the bench follows the scan clock by clock. Every output is compared on every cycle while the grid count is swept through 0, 1, 3, 16, 20 and 25 and the dimmer through 0, 1, 3, 7 and 12. The count of grids seen in a frame tells the clamping of the grid count apart from the sequencing. The total lit-cycle count tells the dimmer clamp at both ends apart from the slot length. Distinct per-row patterns, with stray writes to out-of-range addresses, show whether the segment data comes from the right row and whether it switches only at frame boundaries. Key patterns are changed across all rows, then left unchanged, then changed with fewer than 16 grids and in row 15 alone. This separates the change flag's set and clear from the rule that rows which are not scanned keep their values.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

    // Scan phase of one timing slot.
    typedef enum logic [0:0] {
        ST_BLANK = 1'b0,
        ST_LIT   = 1'b1
    } scan_state_t;

endpackage

// File: rtl/vfd_prescaler.sv
module vfd_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

    generate
        if (DIV >= 2) begin : g_spaced
            // R5: with division of two or more, ticks never come back to back.
            assert_tick_spacing_R5: assert property (
                @(posedge clk) disable iff (!rst_n) tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/vfd_scan_fsm.sv
module vfd_scan_fsm
    import vfd_pkg::*;
#(
    parameter int MAX_GRIDS  = 20,
    parameter int SLOT_TICKS = 16,
    parameter int DIM_W      = 4,
    localparam int GI_W = $clog2(MAX_GRIDS),
    localparam int GC_W = $clog2(MAX_GRIDS + 1),
    localparam int T_W  = $clog2(SLOT_TICKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic [GC_W-1:0]      cfg_grids_i,
    input  logic [DIM_W-1:0]     cfg_dim_i,
    output logic [GI_W-1:0]      slot_o,
    output logic                 lit_o,
    output logic                 slot_end_o,
    output logic                 frame_end_o,
    output logic [MAX_GRIDS-1:0] grid_o
);
    localparam logic [T_W-1:0]  T_LAST = T_W'(SLOT_TICKS - 1);
    localparam logic [GC_W-1:0] G_MAX  = GC_W'(MAX_GRIDS);

    scan_state_t     state_q, state_d;
    logic [T_W-1:0]  tcnt_q;
    logic [T_W-1:0]  dim_eff;
    logic [GI_W-1:0] slot_q;
    logic [GC_W-1:0] ngrid_q;
    logic [GC_W-1:0] ngrid_cfg;
    logic [DIM_W-1:0] dim_q;
    logic            last_tick;
    logic            slot_end;
    logic            frame_end;

    // Dark ticks per slot: at least one, never the whole slot.
    always_comb begin
        if (dim_q == '0) begin
            dim_eff = T_W'(1);
        end else if (32'(dim_q) >= 32'(SLOT_TICKS - 1)) begin
            dim_eff = T_LAST;
        end else begin
            dim_eff = T_W'(dim_q);
        end
    end

    // Requested grid count folded into 1..MAX_GRIDS.
    always_comb begin
        if (cfg_grids_i == '0) begin
            ngrid_cfg = GC_W'(1);
        end else if (cfg_grids_i > G_MAX) begin
            ngrid_cfg = G_MAX;
        end else begin
            ngrid_cfg = cfg_grids_i;
        end
    end

    assign last_tick = (tcnt_q == T_LAST);
    assign slot_end  = tick_i && (state_q == ST_LIT) && last_tick;
    assign frame_end = slot_end && ((32'(slot_q) + 32'd1) == 32'(ngrid_q));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: if (tick_i && (tcnt_q == dim_eff - 1'b1)) state_d = ST_LIT;
            ST_LIT:   if (slot_end)                             state_d = ST_BLANK;
        endcase
    end

    // Slot, tick and frame configuration registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q  <= '0;
            slot_q  <= '0;
            ngrid_q <= GC_W'(1);
            dim_q   <= '0;
        end else begin
            if (tick_i) begin
                tcnt_q <= last_tick ? '0 : tcnt_q + 1'b1;
            end
            if (slot_end) begin
                slot_q <= frame_end ? '0 : slot_q + 1'b1;
            end
            if (frame_end) begin
                ngrid_q <= ngrid_cfg;
                dim_q   <= cfg_dim_i;
            end
        end
    end

    // Outputs.
    always_comb begin
        grid_o = '0;
        lit_o  = (state_q == ST_LIT);
        if (state_q == ST_LIT) begin
            grid_o[slot_q] = 1'b1;
        end
    end

    assign slot_o      = slot_q;
    assign slot_end_o  = slot_end;
    assign frame_end_o = frame_end;

    // R4: active slot inside the latched count, count inside 1..MAX_GRIDS.
    assert_slot_range_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (32'(slot_q) < 32'(ngrid_q)) && (ngrid_q != '0) && (ngrid_q <= G_MAX));

    // R2: never two grids at once.
    assert_grid_onehot_R2: assert property (
        @(posedge clk) disable iff (!rst_n) $onehot0(grid_o));

    // R5: a lit grid is followed by itself or by darkness, never by another grid.
    assert_grid_gap_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (grid_o != '0) |=> ((grid_o == '0) || (grid_o == $past(grid_o))));

endmodule

// File: rtl/vfd_disp_ram.sv
module vfd_disp_ram #(
    parameter int ROWS  = 20,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             load_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);
    // Host-side copy and the copy shown during the current frame.
    logic [ROWS-1:0][WIDTH-1:0] shadow_q;
    logic [ROWS-1:0][WIDTH-1:0] frame_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            frame_q  <= '0;
        end else begin
            if (load_i) begin
                frame_q <= shadow_q;
            end
            if (we_i && (32'(waddr_i) < ROWS)) begin
                shadow_q[waddr_i] <= wdata_i;
            end
        end
    end

    assign rdata_o = frame_q[raddr_i];

    // R6: the shown pattern changes only at a frame boundary.
    assert_frame_hold_R6: assert property (
        @(posedge clk) disable iff (!rst_n) !load_i |=> $stable(frame_q));

endmodule

// File: rtl/vfd_key_matrix.sv
module vfd_key_matrix #(
    parameter int ROWS = 16,
    parameter int COLS = 8,
    parameter int SI_W = 5,
    localparam int RS_W = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_i,
    input  logic [SI_W-1:0] slot_i,
    input  logic [COLS-1:0] ret_i,
    input  logic            frame_end_i,
    input  logic [RS_W-1:0] sel_i,
    output logic [COLS-1:0] row_o,
    output logic            chg_o
);
    logic [ROWS-1:0][COLS-1:0] rows_q;
    logic [RS_W-1:0]           row_idx;
    logic                      hit;
    logic                      this_diff;
    logic                      diff_q;
    logic                      chg_q;

    assign row_idx   = RS_W'(slot_i);
    assign hit       = sample_i && (32'(slot_i) < ROWS);
    assign this_diff = hit && (ret_i != rows_q[row_idx]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows_q <= '0;
            diff_q <= 1'b0;
            chg_q  <= 1'b0;
        end else begin
            if (hit) begin
                rows_q[row_idx] <= ret_i;
            end
            if (frame_end_i) begin
                chg_q  <= diff_q | this_diff;
                diff_q <= 1'b0;
            end else begin
                diff_q <= diff_q | this_diff;
            end
        end
    end

    assign row_o = rows_q[sel_i];
    assign chg_o = chg_q;

    // R8: rows only move on a sample strobe.
    assert_row_hold_R8: assert property (
        @(posedge clk) disable iff (!rst_n) !sample_i |=> $stable(rows_q));

    // R9: the change flag only moves at a frame end.
    assert_chg_hold_R9: assert property (
        @(posedge clk) disable iff (!rst_n) !frame_end_i |=> $stable(chg_q));

endmodule

// File: rtl/vfd_key_scanner.sv
module vfd_key_scanner #(
    parameter int MAX_GRIDS  = 20,
    parameter int SEG_W      = 32,
    parameter int KEY_ROWS   = 16,
    parameter int KEY_COLS   = 8,
    parameter int PRESC_DIV  = 4,
    parameter int SLOT_TICKS = 16,
    parameter int DIM_W      = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            host_we,
    input  logic [$clog2(MAX_GRIDS)-1:0]    host_addr,
    input  logic [SEG_W-1:0]                host_wdata,
    input  logic [$clog2(MAX_GRIDS+1)-1:0]  cfg_grids,
    input  logic [DIM_W-1:0]                cfg_dim,
    input  logic [KEY_COLS-1:0]             key_ret_i,
    input  logic [$clog2(KEY_ROWS)-1:0]     key_sel,
    output logic [KEY_COLS-1:0]             key_row_o,
    output logic                            key_chg_o,
    output logic [MAX_GRIDS-1:0]            grid_o,
    output logic [SEG_W-1:0]                seg_o
);
    localparam int GI_W = $clog2(MAX_GRIDS);

    logic            tick;
    logic [GI_W-1:0] slot;
    logic            lit;
    logic            slot_end;
    logic            frame_end;
    logic [SEG_W-1:0] row_data;

    vfd_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    vfd_scan_fsm #(
        .MAX_GRIDS  (MAX_GRIDS),
        .SLOT_TICKS (SLOT_TICKS),
        .DIM_W      (DIM_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .cfg_grids_i (cfg_grids),
        .cfg_dim_i   (cfg_dim),
        .slot_o      (slot),
        .lit_o       (lit),
        .slot_end_o  (slot_end),
        .frame_end_o (frame_end),
        .grid_o      (grid_o)
    );

    vfd_disp_ram #(
        .ROWS  (MAX_GRIDS),
        .WIDTH (SEG_W)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (host_we),
        .waddr_i (host_addr),
        .wdata_i (host_wdata),
        .load_i  (frame_end),
        .raddr_i (slot),
        .rdata_o (row_data)
    );

    vfd_key_matrix #(
        .ROWS (KEY_ROWS),
        .COLS (KEY_COLS),
        .SI_W (GI_W)
    ) u_keys (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_i    (slot_end),
        .slot_i      (slot),
        .ret_i       (key_ret_i),
        .frame_end_i (frame_end),
        .sel_i       (key_sel),
        .row_o       (key_row_o),
        .chg_o       (key_chg_o)
    );

    assign seg_o = lit ? row_data : '0;

    // R3: anodes are dark whenever no grid is driven.
    assert_dark_seg_R3: assert property (
        @(posedge clk) disable iff (!rst_n) (grid_o == '0) |-> (seg_o == '0));

endmodule

// File: tb/sim_vfd_key_scanner.sv
module sim_vfd_key_scanner;
    localparam int DIV = 2;
    localparam int ST  = 8;
    localparam int NG  = 20;
    localparam int KR  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [4:0]  cfg_grids = '0;
    logic [3:0]  cfg_dim = '0;
    logic [7:0]  key_ret;
    logic [3:0]  key_sel = '0;
    logic [7:0]  key_row_o;
    logic        key_chg_o;
    logic [19:0] grid_o;
    logic [31:0] seg_o;

    int n_checks = 0;
    int n_err = 0;

    vfd_key_scanner #(
        .MAX_GRIDS(NG), .SEG_W(32), .KEY_ROWS(KR), .KEY_COLS(8),
        .PRESC_DIV(DIV), .SLOT_TICKS(ST), .DIM_W(4)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .cfg_grids(cfg_grids), .cfg_dim(cfg_dim),
        .key_ret_i(key_ret), .key_sel(key_sel), .key_row_o(key_row_o),
        .key_chg_o(key_chg_o), .grid_o(grid_o), .seg_o(seg_o)
    );

    always #2 clk = ~clk;

    // Key matrix: the returns show the pressed keys of the driven scan line.
    logic [7:0] keymap [KR];
    always_comb begin
        key_ret = '0;
        for (int g = 0; g < KR; g++) if (grid_o[g]) key_ret |= keymap[g];
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int clamp_g(input int c);
        return (c == 0) ? 1 : ((c > NG) ? NG : c);
    endfunction

    function automatic int clamp_d(input int d);
        return (d == 0) ? 1 : ((d > ST - 1) ? ST - 1 : d);
    endfunction

    function automatic logic [31:0] pat(input int r);
        return 32'((r + 1) * 32'h9E3779B1) ^ 32'(r << 8);
    endfunction

    // Reference model, advanced once per clock from the requirements.
    int          m_pc, m_tc, m_slot, m_ng, m_dim, m_frames;
    bit          m_lit, m_diff, m_chg, m_d, m_tk;
    logic [31:0] m_sh [NG];
    logic [31:0] m_fb [NG];
    logic [7:0]  m_rows [KR];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_tc = 0; m_slot = 0; m_ng = 1; m_dim = 0; m_frames = 0;
            m_lit = 0; m_diff = 0; m_chg = 0;
            for (int r = 0; r < NG; r++) begin m_sh[r] = '0; m_fb[r] = '0; end
            for (int r = 0; r < KR; r++) m_rows[r] = '0;
        end else begin
            m_tk = (m_pc == DIV - 1);
            m_pc = m_tk ? 0 : m_pc + 1;
            if (m_tk) begin
                if (m_tc == ST - 1) begin
                    m_d = 0;
                    if (m_slot < KR) begin
                        m_d = (keymap[m_slot] != m_rows[m_slot]);
                        m_rows[m_slot] = keymap[m_slot];
                    end
                    if (m_slot == m_ng - 1) begin
                        m_slot = 0;
                        m_ng = clamp_g(int'(cfg_grids));
                        m_dim = int'(cfg_dim);
                        for (int r = 0; r < NG; r++) m_fb[r] = m_sh[r];
                        m_chg = m_diff | m_d;
                        m_diff = 0;
                        m_frames++;
                    end else begin
                        m_slot++;
                        m_diff = m_diff | m_d;
                    end
                    m_tc = 0;
                    m_lit = 0;
                end else begin
                    m_tc++;
                    if (m_tc == clamp_d(m_dim)) m_lit = 1;
                end
            end
            if (host_we && (int'(host_addr) < NG)) m_sh[host_addr] = host_wdata;
        end
    end

    // Cycle-by-cycle comparison against the model.
    logic [19:0] e_grid;
    logic [31:0] e_seg;
    always @(negedge clk) begin
        if (rst_n) begin
            e_grid = m_lit ? (20'd1 << m_slot) : 20'd0;
            e_seg  = m_lit ? m_fb[m_slot] : 32'd0;
            chk(grid_o == e_grid, "R2 R5 R7 grid sequence", 64'(grid_o), 64'(e_grid));
            chk(seg_o == e_seg, "R3 R6 segment data", 64'(seg_o), 64'(e_seg));
            chk(key_chg_o == m_chg, "R9 key change flag", 64'(key_chg_o), 64'(m_chg));
        end
    end

    task automatic wait_boundary();
        int f0;
        f0 = m_frames;
        while (m_frames == f0) @(negedge clk);
    endtask

    task automatic host_write(input int a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 5'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic check_rows(input string tag);
        for (int r = 0; r < KR; r++) begin
            @(negedge clk);
            key_sel = 4'(r);
            #1;
            chk(key_row_o == m_rows[r], tag, 64'(key_row_o), 64'(m_rows[r]));
        end
    endtask

    // Called at the first negedge of a frame; observes that whole frame.
    task automatic measure(output int lit_cyc, output logic [19:0] seen,
                           output int seg_bad);
        int f0;
        f0 = m_frames; lit_cyc = 0; seen = '0; seg_bad = 0;
        while (m_frames == f0) begin
            if (grid_o != '0) begin
                lit_cyc++;
                seen |= grid_o;
                for (int g = 0; g < NG; g++)
                    if (grid_o[g] && seg_o != pat(g)) seg_bad++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int glist [6] = '{0, 1, 3, 16, 20, 25};
        int dlist [5] = '{0, 1, 3, 7, 12};
        int lc, sb, eng, edim;
        logic [19:0] seen;
        bit other;
        for (int g = 0; g < KR; g++) keymap[g] = '0;
        cfg_grids = 5'd20;
        repeat (4) @(negedge clk);
        // R1: reset state at the ports.
        chk(grid_o == '0, "R1 grid after reset", 64'(grid_o), 0);
        chk(seg_o == '0, "R1 seg after reset", 64'(seg_o), 0);
        chk(key_chg_o == 1'b0, "R1 key flag after reset", 64'(key_chg_o), 0);
        for (int r = 0; r < KR; r++) begin
            key_sel = 4'(r); #1;
            chk(key_row_o == '0, "R1 key row after reset", 64'(key_row_o), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1: the first frame scans only grid 0.
        other = 0;
        while (m_frames == 0) begin
            if ((grid_o & ~20'd1) != '0) other = 1;
            @(negedge clk);
        end
        chk(!other, "R1 first frame single grid", 64'(other), 0);

        // R6: rows in range plus stray high addresses.
        for (int r = 0; r < NG; r++) host_write(r, pat(r));
        for (int a = NG; a < 32; a++) host_write(a, 32'hFFFF_FFFF);
        cfg_grids = 5'd20; cfg_dim = 4'd0;
        wait_boundary();
        wait_boundary();
        measure(lc, seen, sb);
        chk(sb == 0, "R3 R6 rows match written patterns", 64'(sb), 0);

        // R4 R5 R7: sweep grid count and dimmer.
        foreach (glist[i]) begin
            foreach (dlist[j]) begin
                @(negedge clk);
                cfg_grids = 5'(glist[i]); cfg_dim = 4'(dlist[j]);
                wait_boundary();
                measure(lc, seen, sb);
                eng = clamp_g(glist[i]); edim = clamp_d(dlist[j]);
                chk(seen == 20'((64'd1 << eng) - 1), "R4 grids scanned", 64'(seen),
                    (64'd1 << eng) - 1);
                chk(lc == eng * (ST - edim) * DIV, "R5 lit cycles per frame", 64'(lc),
                    64'(eng * (ST - edim) * DIV));
            end
        end

        // R6: a mid-frame write shows only from the next frame.
        @(negedge clk);
        cfg_grids = 5'd20; cfg_dim = 4'd2;
        wait_boundary();
        host_write(19, 32'h1234_5678);
        while (!grid_o[19]) @(negedge clk);
        chk(seg_o == pat(19), "R6 old row until boundary", 64'(seg_o), 64'(pat(19)));
        wait_boundary();
        while (!grid_o[19]) @(negedge clk);
        chk(seg_o == 32'h1234_5678, "R6 new row after boundary", 64'(seg_o),
            64'h1234_5678);

        // R8 R9: all rows change, then no change.
        wait_boundary();
        for (int g = 0; g < KR; g++) keymap[g] = 8'(g * 17 + 3);
        wait_boundary();
        chk(key_chg_o == 1'b1, "R9 flag set on change", 64'(key_chg_o), 1);
        check_rows("R8 rows captured");
        wait_boundary();
        wait_boundary();
        chk(key_chg_o == 1'b0, "R9 flag clear without change", 64'(key_chg_o), 0);

        // R8: with four grids only rows 0..3 move.
        @(negedge clk);
        cfg_grids = 5'd4;
        wait_boundary();
        for (int g = 0; g < KR; g++) keymap[g] = 8'(~(g * 5));
        wait_boundary();
        check_rows("R8 unscanned rows kept");
        chk(key_chg_o == 1'b1, "R9 flag with short frame", 64'(key_chg_o), 1);

        // R9: a change in row 15 alone.
        @(negedge clk);
        cfg_grids = 5'd20;
        wait_boundary();
        wait_boundary();
        wait_boundary();
        keymap[15] = 8'h81;
        wait_boundary();
        chk(key_chg_o == 1'b1, "R9 flag from last key row", 64'(key_chg_o), 1);
        check_rows("R8 last row captured");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule